// File: doc/BRIEF.md
# Byte-Wide Host Write Port

This block lets a host processor load a display controller's memories and registers over a narrow bus. The host lowers an active-low chip select and presents bytes on an 8-bit bus, one per rising edge of its own write clock. Five consecutive bytes make one write frame. The first two bytes carry a 10-bit word address. The last three bytes carry an 18-bit data word, least significant byte first. The write clock and chip select are asynchronous to the system clock, so both pass through a two-stage synchroniser before the block acts on them.

When a frame completes, the block decodes the address into one of three regions and raises one write-enable pulse for that region, lasting a single system clock: display RAM, the control register bank, or symbol RAM. Display RAM and symbol RAM sit outside the block and take the pulse together with the address and data outputs. The control register bank is held inside the block and is visible as one flat vector. Driving the auto-clear input low resets the interface immediately, drops any partial frame and zeroes every control register.

Top module: `host_byte_writer`

## Requirements
- R1: While `autoClearN` is low, `regionWe` is 0, all of `ctrlRegs` is 0, and any partially received frame is discarded.
- R2: A frame is five bytes. Byte 0 is address bits 7..0 and bits 1..0 of byte 1 are address bits 9..8. Byte 2 is data bits 7..0, byte 3 is data bits 15..8, and bits 1..0 of byte 4 are data bits 17..16. Bits 7..2 of bytes 1 and 4 are ignored.
- R3: A byte is taken only on a rising edge of `wrClk` while `chipSelN` is low. Edges that arrive while `chipSelN` is high take no byte and produce no write.
- R4: Raising `chipSelN` before the fifth byte drops the bytes received so far. The next byte taken after `chipSelN` falls again is byte 0 of a new frame.
- R5: A frame whose address is in 0x000..0x2A7 pulses `regionWe[0]` (display RAM).
- R6: A frame whose address is in 0x2A8..0x2B0 pulses `regionWe[1]`. On the clock after the pulse, `ctrlRegs[k*18 +: 18]` holds the frame's data, where k is the address minus 0x2A8. The other control registers are left unchanged.
- R7: A frame whose address is in 0x300..0x36C pulses `regionWe[2]` (symbol RAM).
- R8: A frame whose address is in 0x2B1..0x2FF or 0x36D..0x3FF raises no bit of `regionWe` and leaves `ctrlRegs` unchanged.
- R9: A write pulse lasts exactly one system clock and has at most one bit set. It first appears three system clocks after the rising `wrClk` that carries the fifth byte. `wrAddr` and `wrData` hold the frame's address and data while the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| autoClearN | input | 1 | Asynchronous auto-clear, active low |
| chipSelN | input | 1 | Host chip select, active low, asynchronous |
| wrClk | input | 1 | Host byte clock; a byte is taken on its rising edge |
| busData | input | 8 | Host byte bus |
| regionWe | output | 3 | One-clock write pulse: bit 0 display RAM, bit 1 control bank, bit 2 symbol RAM |
| wrAddr | output | 10 | Address of the completed frame |
| wrData | output | 18 | Data word of the completed frame |
| ctrlRegs | output | 162 | Control bank, register k at bits k*18 +: 18 |

## Verification
The hardest case to reach is chip select being released in the middle of a frame. When that happens the byte counter must restart, so that a later frame is not shifted by the leftover bytes. The stimulus sends three bytes, raises chip select for several system clocks, then sends a full frame to a control register. Any leftover byte would write the wrong register or the wrong data. The auto-clear is also applied two bytes into a frame, and the frame sent after the release must still land intact.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  typedef enum logic [1:0] {
    REG_DISP = 2'd0,
    REG_CTRL = 2'd1,
    REG_SYM  = 2'd2,
    REG_NONE = 2'd3
  } region_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       capture;  // take busData into the current slot
    logic [2:0] slot;     // byte position inside the frame
    logic       fire;     // frame complete, issue write this cycle
  } ctl_cmd_t;
endpackage

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
  import hbw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BYTES = 5
) (
  input  logic     clk,
  input  logic     autoClearN,
  input  logic     wrClk,
  input  logic     chipSelN,
  output ctl_cmd_t cmd
);
  localparam int CW = $clog2(FRAME_BYTES);

  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic [CW-1:0]          slotCnt;
  logic                   fireQ;
  logic                   rising;
  logic                   csLow;
  logic                   lastSlot;

  always_ff @(posedge clk or negedge autoClearN) begin
    if (!autoClearN) begin
      clkPipe <= '0;
      csPipe  <= '1;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-1:0], wrClk};
      csPipe  <= {csPipe[SYNC_STAGES-2:0], chipSelN};
    end
  end

  assign rising   = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
  assign csLow    = ~csPipe[SYNC_STAGES-1];
  assign lastSlot = (slotCnt == CW'(FRAME_BYTES - 1));

  always_ff @(posedge clk or negedge autoClearN) begin
    if (!autoClearN) begin
      slotCnt <= '0;
      fireQ   <= 1'b0;
    end else begin
      fireQ <= rising & csLow & lastSlot;
      if (!csLow)
        slotCnt <= '0;
      else if (rising)
        slotCnt <= lastSlot ? '0 : slotCnt + 1'b1;
    end
  end

  assign cmd.capture = rising & csLow;
  assign cmd.slot    = 3'(slotCnt);
  assign cmd.fire    = fireQ;
endmodule

// File: rtl/hbw_datapath.sv
module hbw_datapath
  import hbw_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int ADDR_BYTES = 2,
  parameter int NUM_CTRL = 9,
  parameter logic [ADDR_W-1:0] DISP_LAST  = 'h2A7,
  parameter logic [ADDR_W-1:0] CTRL_FIRST = 'h2A8,
  parameter logic [ADDR_W-1:0] CTRL_LAST  = 'h2B0,
  parameter logic [ADDR_W-1:0] SYM_FIRST  = 'h300,
  parameter logic [ADDR_W-1:0] SYM_LAST   = 'h36C
) (
  input  logic                       clk,
  input  logic                       autoClearN,
  input  ctl_cmd_t                   cmd,
  input  logic [BYTE_W-1:0]          busData,
  output logic [2:0]                 regionWe,
  output logic [ADDR_W-1:0]          wrAddr,
  output logic [DATA_W-1:0]          wrData,
  output logic [NUM_CTRL*DATA_W-1:0] ctrlRegs
);
  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [DATA_W-1:0] dataReg, dataNext;
  region_e           region;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++)
      addrNext[i] = (cmd.capture && cmd.slot == 3'(i / BYTE_W))
                    ? busData[i % BYTE_W] : addrReg[i];
    for (int i = 0; i < DATA_W; i++)
      dataNext[i] = (cmd.capture && cmd.slot == 3'(ADDR_BYTES + i / BYTE_W))
                    ? busData[i % BYTE_W] : dataReg[i];
  end

  always_ff @(posedge clk or negedge autoClearN) begin
    if (!autoClearN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      addrReg <= addrNext;
      dataReg <= dataNext;
    end
  end

  always_comb begin
    if (addrReg <= DISP_LAST)
      region = REG_DISP;
    else if (addrReg >= CTRL_FIRST && addrReg <= CTRL_LAST)
      region = REG_CTRL;
    else if (addrReg >= SYM_FIRST && addrReg <= SYM_LAST)
      region = REG_SYM;
    else
      region = REG_NONE;
  end

  always_comb begin
    regionWe = '0;
    if (cmd.fire && region != REG_NONE)
      regionWe[region] = 1'b1;
  end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk or negedge autoClearN) begin
      if (!autoClearN)
        word <= '0;
      else if (cmd.fire && region == REG_CTRL && addrReg == CTRL_FIRST + ADDR_W'(g))
        word <= dataReg;
    end
    assign ctrlRegs[g*DATA_W +: DATA_W] = word;
  end

  assign wrAddr = addrReg;
  assign wrData = dataReg;
endmodule

// File: rtl/host_byte_writer.sv
module host_byte_writer
  import hbw_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DISP_LAST  = 'h2A7,
  parameter logic [ADDR_W-1:0] CTRL_FIRST = 'h2A8,
  parameter logic [ADDR_W-1:0] CTRL_LAST  = 'h2B0,
  parameter logic [ADDR_W-1:0] SYM_FIRST  = 'h300,
  parameter logic [ADDR_W-1:0] SYM_LAST   = 'h36C,
  localparam int NUM_CTRL = int'(CTRL_LAST - CTRL_FIRST) + 1
) (
  input  logic                       clk,
  input  logic                       autoClearN,
  input  logic                       chipSelN,
  input  logic                       wrClk,
  input  logic [BYTE_W-1:0]          busData,
  output logic [2:0]                 regionWe,
  output logic [ADDR_W-1:0]          wrAddr,
  output logic [DATA_W-1:0]          wrData,
  output logic [NUM_CTRL*DATA_W-1:0] ctrlRegs
);
  localparam int ADDR_BYTES  = (ADDR_W + BYTE_W - 1) / BYTE_W;
  localparam int DATA_BYTES  = (DATA_W + BYTE_W - 1) / BYTE_W;
  localparam int FRAME_BYTES = ADDR_BYTES + DATA_BYTES;

  ctl_cmd_t cmd;

  hbw_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BYTES(FRAME_BYTES)
  ) u_ctrl (
    .clk(clk),
    .autoClearN(autoClearN),
    .wrClk(wrClk),
    .chipSelN(chipSelN),
    .cmd(cmd)
  );

  hbw_datapath #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_BYTES(ADDR_BYTES), .NUM_CTRL(NUM_CTRL),
    .DISP_LAST(DISP_LAST), .CTRL_FIRST(CTRL_FIRST), .CTRL_LAST(CTRL_LAST),
    .SYM_FIRST(SYM_FIRST), .SYM_LAST(SYM_LAST)
  ) u_dp (
    .clk(clk),
    .autoClearN(autoClearN),
    .cmd(cmd),
    .busData(busData),
    .regionWe(regionWe),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .ctrlRegs(ctrlRegs)
  );
endmodule

// File: rtl/hbw_chk.sv
module hbw_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int NUM_CTRL = 9,
  parameter logic [ADDR_W-1:0] CTRL_FIRST = 'h2A8,
  parameter logic [ADDR_W-1:0] CTRL_LAST  = 'h2B0,
  parameter logic [ADDR_W-1:0] SYM_FIRST  = 'h300,
  parameter logic [ADDR_W-1:0] SYM_LAST   = 'h36C
) (
  input logic                       clk,
  input logic                       autoClearN,
  input logic [2:0]                 regionWe,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [DATA_W-1:0]          wrData,
  input logic [NUM_CTRL*DATA_W-1:0] ctrlRegs
);
  int lastIdx;
  always_ff @(posedge clk) lastIdx <= int'(wrAddr) - int'(CTRL_FIRST);

  // R9
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!autoClearN)
    $onehot0(regionWe));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!autoClearN)
    (regionWe != 3'b000) |=> (regionWe == 3'b000));

  // R8
  gap_silent_chk: assert property (@(posedge clk) disable iff (!autoClearN)
    ((wrAddr > CTRL_LAST && wrAddr < SYM_FIRST) || wrAddr > SYM_LAST) |-> (regionWe == 3'b000));

  // R6
  ctrl_lands_chk: assert property (@(posedge clk) disable iff (!autoClearN)
    regionWe[1] |=> (ctrlRegs[lastIdx*DATA_W +: DATA_W] == $past(wrData)));

  // R8
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (!autoClearN)
    !$stable(ctrlRegs) |-> $past(regionWe[1]));
endmodule

bind host_byte_writer hbw_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL),
  .CTRL_FIRST(CTRL_FIRST), .CTRL_LAST(CTRL_LAST),
  .SYM_FIRST(SYM_FIRST), .SYM_LAST(SYM_LAST)
) u_chk (
  .clk(clk), .autoClearN(autoClearN), .regionWe(regionWe),
  .wrAddr(wrAddr), .wrData(wrData), .ctrlRegs(ctrlRegs)
);

// File: tb/host_byte_writer_test.sv
module host_byte_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 9;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic autoClearN, chipSelN, wrClk;
  logic [7:0] busData;
  logic [2:0] regionWe;
  logic [9:0] wrAddr;
  logic [DW-1:0] wrData;
  logic [NC*DW-1:0] ctrlRegs;

  host_byte_writer uut (
    .clk(clk), .autoClearN(autoClearN), .chipSelN(chipSelN), .wrClk(wrClk),
    .busData(busData), .regionWe(regionWe), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlRegs(ctrlRegs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R1";
  logic [7:0] mBytes[$];
  logic [NC*DW-1:0] expCtrl = '0;
  bit evValid = 0;
  int evCyc, evRegion, evAddr;
  logic [DW-1:0] evData;

  function automatic int regionOf(int a);
    if (a <= 'h2A7) return 0;
    if (a <= 'h2B0) return 1;
    if (a >= 'h300 && a <= 'h36C) return 2;
    return 3;
  endfunction

  task automatic check(string t, logic [255:0] act, logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", t, cyc, act, exp);
    end
  endtask

  // reference comparison on every system clock
  task automatic tick();
    logic [2:0] expWe;
    @(negedge clk);
    cyc++;
    if (evValid && evRegion == 1 && cyc == evCyc + 1)
      expCtrl[(evAddr - 'h2A8)*DW +: DW] = evData;
    expWe = (evValid && cyc == evCyc && evRegion < 3) ? (3'b001 << evRegion) : 3'b000;
    check({tag, "/R9 pulse"}, 256'(regionWe), 256'(expWe));
    if (expWe != 0) begin
      check({tag, "/R9 addr"}, 256'(wrAddr), 256'(evAddr));
      check({tag, "/R9 data"}, 256'(wrData), 256'(evData));
    end
    check({tag, " ctrl bank"}, 256'(ctrlRegs), 256'(expCtrl));
    if (evValid && cyc > evCyc + 1) evValid = 0;
  endtask

  task automatic sendByte(logic [7:0] b);
    busData = b;
    tick();
    wrClk = 1'b1;
    if (!chipSelN) begin
      mBytes.push_back(b);
      if (mBytes.size() == 5) begin
        evValid  = 1;
        evCyc    = cyc + 3;
        evAddr   = {mBytes[1][1:0], mBytes[0]};
        evData   = {mBytes[4][1:0], mBytes[3], mBytes[2]};
        evRegion = regionOf(evAddr);
        mBytes.delete();
      end
    end
    repeat (3) tick();
    wrClk = 1'b0;
    repeat (3) tick();
  endtask

  task automatic setCs(logic v);
    chipSelN = v;
    if (v) mBytes.delete();
    repeat (4) tick();
  endtask

  // R2: upper bits of bytes 1 and 4 carry junk that must be ignored
  task automatic sendFrame(int a, logic [DW-1:0] d);
    sendByte(a[7:0]);
    sendByte({6'b101101, a[9:8]});
    sendByte(d[7:0]);
    sendByte(d[15:8]);
    sendByte({6'b110011, d[17:16]});
    repeat (3) tick();
  endtask

  task automatic clearPulse();
    autoClearN = 1'b0;
    mBytes.delete();
    expCtrl = '0;
    evValid = 0;
    repeat (2) tick();
    autoClearN = 1'b1;
    tick();
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    autoClearN = 1'b0; chipSelN = 1'b1; wrClk = 1'b0; busData = 8'h00;
    tag = "R1";
    repeat (3) tick();
    autoClearN = 1'b1;
    repeat (2) tick();

    setCs(1'b0);
    tag = "R2"; sendFrame('h155, 18'h2A5C3);
    tag = "R5"; sendFrame('h000, 18'h3FFFF); sendFrame('h2A7, 18'h00001);
    tag = "R6"; sendFrame('h2A8, 18'h12345); sendFrame('h2B0, 18'h3C0F0);
    sendFrame('h2AC, 18'h0BEEF); sendFrame('h2A8, 18'h20001);
    tag = "R7"; sendFrame('h300, 18'h1ABCD); sendFrame('h36C, 18'h2F00F);
    tag = "R8"; sendFrame('h2B1, 18'h3FFFF); sendFrame('h2FF, 18'h11111);
    sendFrame('h36D, 18'h22222); sendFrame('h3FF, 18'h33333);

    tag = "R3";
    setCs(1'b1);
    sendFrame('h2A9, 18'h3AAAA);
    setCs(1'b0);
    sendFrame('h2AA, 18'h15555);

    tag = "R4";
    sendByte(8'hAE); sendByte(8'h02); sendByte(8'h77);
    setCs(1'b1);
    setCs(1'b0);
    sendFrame('h2A9, 18'h0C3C3);

    tag = "R1";
    sendByte(8'hAB); sendByte(8'h02);
    clearPulse();
    repeat (3) tick();
    sendFrame('h2AD, 18'h24680);
    repeat (5) tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule